// File: doc/BRIEF.md
# Guarded Configuration and Read-Pointer Register Bank

This block is the register bank that a serial host interface talks to on behalf of a bus master controller. It holds three readable registers: a four-bit feature configuration, a status byte, and a read-data byte. It has no read address. A read pointer decides which register the host's next read returns, and each executed command leaves that pointer where the command implies. Writes to the configuration are guarded: a data byte is accepted only when its upper nibble is the bitwise inverse of its lower nibble.

Commands arrive as decoded strobes on a valid/ready channel. `cmd_ready` drops while a bus operation is outstanding. A command offered during that time waits, and the host keeps `cmd_valid`, `cmd_op` and `cmd_data` steady until the handshake. A device-reset command is the one exception: it is accepted at any time. A command that starts a bus operation places a request on a second valid/ready channel towards the bus engine. The request holds its kind and payload until `req_ready` is seen. The engine reports the end of the operation with a single-cycle `done_valid` strobe, and it reports the end of a strong-pullup phase with `spu_done`.

Top module: `regbank_top`

## Requirements
- R1: After `rst_n` or an accepted device-reset command (op 0), the configuration is 0, the pointer selects status (`rd_sel`=0), status reads 8'h08 (only the reset flag, bit 3, set), read data is 0 and no request is pending.
- R2: Write-config (op 1) loads `cmd_data[3:0]` into the configuration only when `cmd_data[7:4]` equals `~cmd_data[3:0]`. Otherwise the configuration is unchanged. In both cases the pointer moves to configuration (`rd_sel`=2).
- R3: A read with the pointer on configuration returns 0 in bits 7:4 and the configuration in bits 3:0. `feat` drives bit 0 active pullup, bit 1 presence masking, bit 2 strong pullup and bit 3 speed select.
- R4: A `spu_done` pulse clears configuration bit 2 by the next cycle and leaves bits 0, 1 and 3 unchanged. A valid write-config in the same cycle takes precedence.
- R5: Set-pointer (op 2) selects status, read data or configuration for `cmd_data[1:0]` equal to 0, 1 or 2. The code 3 leaves the pointer unchanged. Ops 6 and 7 are accepted and have no effect.
- R6: Line reset (op 3), write byte (op 4) and read byte (op 5) raise `req_valid` with `req_kind` 0, 1 or 2 and `req_data`=`cmd_data`. The request is held steady until `req_ready`. The command moves the pointer to status and sets status bit 0 (busy).
- R7: While busy, `cmd_ready` is low for every op except device reset.
- R8: `done_valid` while busy clears busy. For a line reset it loads status bit 1 from `done_presence` and bit 2 from `done_short`. For a read byte it loads read data from `done_byte`. `done_valid` while idle changes nothing.
- R9: A device reset accepted while busy drops the pending request and the busy flag on the next cycle.
- R10: The reset flag (status bit 3) clears on the first accepted valid write-config. A rejected write leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 8 | Command data byte |
| req_valid | output | 1 | Bus operation request pending |
| req_ready | input | 1 | Engine takes the request |
| req_kind | output | 2 | 0 line reset, 1 write byte, 2 read byte |
| req_data | output | 8 | Byte to write |
| done_valid | input | 1 | Engine finished the operation |
| done_presence | input | 1 | Presence seen during line reset |
| done_short | input | 1 | Short seen during line reset |
| done_byte | input | 8 | Byte read from the line |
| spu_done | input | 1 | Strong-pullup phase ended |
| feat | output | 4 | Feature enables to the bus engine |
| rd_sel | output | 2 | Current pointer: 0 status, 1 read data, 2 config |
| rd_data | output | 8 | Byte a host read returns |

## Verification
The bench targets four kinds of corner case.

- **Near-miss complement bytes.** A guard that checked only part of the nibble relation would take a corrupt configuration byte. The same mistake would also clear the reset flag.
- **`spu_done` coinciding with a valid write.** A design with the wrong priority would lose the newly written strong-pullup bit.
- **Commands offered while a request is held off by `req_ready`, and a device reset against a pending request.** A design without the stall would retarget a live request or start a second one. A design that ignores reset would leave the engine with a request nobody awaits.
- **Set-pointer code 3, spare ops, and `done_valid` while idle.** A design that handled these wrongly would move the pointer or overwrite status behind the host's back.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [2:0] {
    CMD_DEV_RST  = 3'd0,
    CMD_WR_CFG   = 3'd1,
    CMD_SET_PTR  = 3'd2,
    CMD_LINE_RST = 3'd3,
    CMD_WR_BYTE  = 3'd4,
    CMD_RD_BYTE  = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    PTR_STATUS = 2'd0,
    PTR_RDATA  = 2'd1,
    PTR_CONFIG = 2'd2
  } ptr_e;

  typedef enum logic [1:0] {
    OPK_LINE_RST = 2'd0,
    OPK_WR_BYTE  = 2'd1,
    OPK_RD_BYTE  = 2'd2
  } opk_e;

  // feature bit positions decoded by the bus engine
  localparam int FEAT_APU  = 0;
  localparam int FEAT_PPM  = 1;
  localparam int FEAT_SPU  = 2;
  localparam int FEAT_SPD  = 3;

  // status flag positions
  localparam int ST_BUSY   = 0;
  localparam int ST_PRES   = 1;
  localparam int ST_SHORT  = 2;
  localparam int ST_RFLAG  = 3;
  localparam int ST_FLAGS  = 4;

endpackage

// File: rtl/regbank_cfg_guard.sv
module regbank_cfg_guard #(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dev_rst,
  input  logic               wr_en,
  input  logic [2*NIB_W-1:0] wr_data,
  input  logic               spu_clr,
  output logic [NIB_W-1:0]   cfg,
  output logic               wr_ok
);
  import regbank_pkg::*;

  localparam int DATA_W = 2 * NIB_W;

  logic [NIB_W-1:0] lo_nib, hi_nib;
  logic [NIB_W-1:0] cfg_q;

  assign lo_nib = wr_data[NIB_W-1:0];
  assign hi_nib = wr_data[DATA_W-1:NIB_W];
  assign wr_ok  = wr_en && (hi_nib == ~lo_nib);
  assign cfg    = cfg_q;

  for (genvar gi = 0; gi < NIB_W; gi++) begin : g_bit
    if (gi == FEAT_SPU) begin : g_self_clear
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cfg_q[gi] <= 1'b0;
        else if (dev_rst) cfg_q[gi] <= 1'b0;
        else if (wr_ok)   cfg_q[gi] <= lo_nib[gi];
        else if (spu_clr) cfg_q[gi] <= 1'b0;
      end
    end else begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cfg_q[gi] <= 1'b0;
        else if (dev_rst) cfg_q[gi] <= 1'b0;
        else if (wr_ok)   cfg_q[gi] <= lo_nib[gi];
      end
    end
  end

endmodule

// File: rtl/regbank_ptr_ctl.sv
module regbank_ptr_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dev_rst,
  input  logic       wr_cfg,
  input  logic       set_ptr,
  input  logic [1:0] sel_code,
  input  logic       bus_op,
  output logic [1:0] ptr
);
  import regbank_pkg::*;

  ptr_e ptr_q;

  assign ptr = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= PTR_STATUS;
    else if (dev_rst) ptr_q <= PTR_STATUS;
    else if (wr_cfg)  ptr_q <= PTR_CONFIG;
    else if (bus_op)  ptr_q <= PTR_STATUS;
    else if (set_ptr) begin
      case (sel_code)
        2'd0:    ptr_q <= PTR_STATUS;
        2'd1:    ptr_q <= PTR_RDATA;
        2'd2:    ptr_q <= PTR_CONFIG;
        default: ptr_q <= ptr_q;
      endcase
    end
  end

endmodule

// File: rtl/regbank_op_ctl.sv
module regbank_op_ctl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_rst,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic [DATA_W-1:0] op_data,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [1:0]        req_kind,
  output logic [DATA_W-1:0] req_data,
  input  logic              done_valid,
  input  logic              done_presence,
  input  logic              done_short,
  input  logic [DATA_W-1:0] done_byte,
  input  logic              cfg_ok,
  output logic              busy,
  output logic [3:0]        flags,
  output logic [DATA_W-1:0] rdata
);
  import regbank_pkg::*;

  logic              req_q, busy_q, pres_q, short_q, rflag_q;
  opk_e              kind_q;
  logic [DATA_W-1:0] rqd_q, rdata_q;
  logic              finish;

  assign finish    = done_valid && busy_q;
  assign req_valid = req_q;
  assign req_kind  = kind_q;
  assign req_data  = rqd_q;
  assign busy      = busy_q;
  assign rdata     = rdata_q;

  always_comb begin
    flags           = '0;
    flags[ST_BUSY]  = busy_q;
    flags[ST_PRES]  = pres_q;
    flags[ST_SHORT] = short_q;
    flags[ST_RFLAG] = rflag_q;
  end

  // request channel and busy flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
      kind_q <= OPK_LINE_RST;
      rqd_q  <= '0;
    end else if (dev_rst) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
    end else if (op_start) begin
      req_q  <= 1'b1;
      busy_q <= 1'b1;
      kind_q <= opk_e'(op_kind);
      rqd_q  <= op_data;
    end else begin
      if (req_q && req_ready) req_q  <= 1'b0;
      if (finish)             busy_q <= 1'b0;
    end
  end

  // result capture and reset flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q  <= 1'b0;
      short_q <= 1'b0;
      rflag_q <= 1'b1;
      rdata_q <= '0;
    end else if (dev_rst) begin
      pres_q  <= 1'b0;
      short_q <= 1'b0;
      rflag_q <= 1'b1;
      rdata_q <= '0;
    end else begin
      if (cfg_ok) rflag_q <= 1'b0;
      if (finish && kind_q == OPK_LINE_RST) begin
        pres_q  <= done_presence;
        short_q <= done_short;
      end
      if (finish && kind_q == OPK_RD_BYTE) rdata_q <= done_byte;
    end
  end

endmodule

// File: rtl/regbank_top.sv
module regbank_top #(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2:0]         cmd_op,
  input  logic [2*NIB_W-1:0] cmd_data,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [1:0]         req_kind,
  output logic [2*NIB_W-1:0] req_data,
  input  logic               done_valid,
  input  logic               done_presence,
  input  logic               done_short,
  input  logic [2*NIB_W-1:0] done_byte,
  input  logic               spu_done,
  output logic [NIB_W-1:0]   feat,
  output logic [1:0]         rd_sel,
  output logic [2*NIB_W-1:0] rd_data
);
  import regbank_pkg::*;

  localparam int DATA_W = 2 * NIB_W;

  logic              busy, accept;
  logic              dev_rst, wr_cfg, set_ptr, bus_op, cfg_ok;
  logic [1:0]        op_kind;
  logic [3:0]        flags;
  logic [DATA_W-1:0] rdata;
  logic [NIB_W-1:0]  cfg;

  assign cmd_ready = !busy || (cmd_op == CMD_DEV_RST);
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    dev_rst = 1'b0;
    wr_cfg  = 1'b0;
    set_ptr = 1'b0;
    bus_op  = 1'b0;
    op_kind = OPK_LINE_RST;
    if (accept) begin
      case (cmd_op)
        CMD_DEV_RST:  dev_rst = 1'b1;
        CMD_WR_CFG:   wr_cfg  = 1'b1;
        CMD_SET_PTR:  set_ptr = 1'b1;
        CMD_LINE_RST: begin bus_op = 1'b1; op_kind = OPK_LINE_RST; end
        CMD_WR_BYTE:  begin bus_op = 1'b1; op_kind = OPK_WR_BYTE;  end
        CMD_RD_BYTE:  begin bus_op = 1'b1; op_kind = OPK_RD_BYTE;  end
        default: ;
      endcase
    end
  end

  regbank_cfg_guard #(.NIB_W(NIB_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .wr_en(wr_cfg),
    .wr_data(cmd_data), .spu_clr(spu_done), .cfg(cfg), .wr_ok(cfg_ok)
  );

  regbank_ptr_ctl u_ptr (
    .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .wr_cfg(wr_cfg),
    .set_ptr(set_ptr), .sel_code(cmd_data[1:0]), .bus_op(bus_op), .ptr(rd_sel)
  );

  regbank_op_ctl #(.DATA_W(DATA_W)) u_op (
    .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .op_start(bus_op),
    .op_kind(op_kind), .op_data(cmd_data), .req_ready(req_ready),
    .req_valid(req_valid), .req_kind(req_kind), .req_data(req_data),
    .done_valid(done_valid), .done_presence(done_presence),
    .done_short(done_short), .done_byte(done_byte), .cfg_ok(cfg_ok),
    .busy(busy), .flags(flags), .rdata(rdata)
  );

  assign feat = cfg;

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      PTR_STATUS: rd_data[ST_FLAGS-1:0] = flags;
      PTR_RDATA:  rd_data = rdata;
      PTR_CONFIG: rd_data[NIB_W-1:0] = cfg;
      default:    rd_data = '0;
    endcase
  end

endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
  parameter int NIB_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [2:0]         cmd_op,
  input logic [2*NIB_W-1:0] cmd_data,
  input logic               req_valid,
  input logic               req_ready,
  input logic [1:0]         req_kind,
  input logic [2*NIB_W-1:0] req_data,
  input logic               spu_done,
  input logic [NIB_W-1:0]   feat,
  input logic [1:0]         rd_sel,
  input logic [2*NIB_W-1:0] rd_data
);
  localparam int DATA_W = 2 * NIB_W;

  logic acc, is_rst, is_wr, bad_wr, is_bus;
  assign acc    = cmd_valid && cmd_ready;
  assign is_rst = acc && cmd_op == 3'd0;
  assign is_wr  = acc && cmd_op == 3'd1;
  assign bad_wr = is_wr && (cmd_data[DATA_W-1:NIB_W] != ~cmd_data[NIB_W-1:0]);
  assign is_bus = acc && (cmd_op == 3'd3 || cmd_op == 3'd4 || cmd_op == 3'd5);

  assert_cfg_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel == 2'd2 |-> rd_data[DATA_W-1:NIB_W] == '0);

  assert_bad_write_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr && !spu_done |=> $stable(feat) && rd_sel == 2'd2);

  assert_dev_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_rst |=> feat == '0 && rd_sel == 2'd0 && !req_valid && cmd_ready);

  assert_spu_self_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spu_done && !is_wr && !is_rst |=> !feat[2]);

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !is_rst |=> req_valid && $stable(req_kind) && $stable(req_data));

  assert_busy_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_bus |=> rd_sel == 2'd0 && rd_data[0] && (cmd_ready == (cmd_op == 3'd0)));

  assert_set_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 3'd2 && cmd_data[1:0] != 2'd3 |=> rd_sel == $past(cmd_data[1:0]));

endmodule

bind regbank_top regbank_chk #(.NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_data(cmd_data), .req_valid(req_valid),
  .req_ready(req_ready), .req_kind(req_kind), .req_data(req_data),
  .spu_done(spu_done), .feat(feat), .rd_sel(rd_sel), .rd_data(rd_data)
);

// File: tb/tb_regbank_top.sv
`timescale 1ns/1ps
module tb_regbank_top;
  logic       clk = 0, rst_n = 0;
  logic       cmd_valid = 0, req_ready = 0, done_valid = 0;
  logic       done_presence = 0, done_short = 0, spu_done = 0;
  logic [2:0] cmd_op = 0;
  logic [7:0] cmd_data = 0, done_byte = 0;
  logic       cmd_ready, req_valid;
  logic [1:0] req_kind, rd_sel;
  logic [7:0] req_data, rd_data;
  logic [3:0] feat;

  always #4 clk = ~clk;

  regbank_top dut (.*);

  int vectors = 0, errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_cfg, m_ptr, m_busy, m_pres, m_short, m_rflag, m_rdata, m_reqv, m_kind, m_rqd;

  function automatic int m_status();
    return m_rflag * 8 + m_short * 4 + m_pres * 2 + m_busy;
  endfunction

  function automatic int m_read();
    if (m_ptr == 0) return m_status();
    if (m_ptr == 1) return m_rdata;
    return m_cfg;
  endfunction

  task automatic m_init();
    m_cfg = 0; m_ptr = 0; m_busy = 0; m_pres = 0; m_short = 0;
    m_rflag = 1; m_rdata = 0; m_reqv = 0; m_kind = 0; m_rqd = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_init();
    else begin
      int rdy;
      rdy = (m_busy == 0 || cmd_op == 0) ? 1 : 0;
      if (m_reqv != 0 && req_ready) m_reqv = 0;
      if (done_valid && m_busy != 0) begin
        m_busy = 0;
        if (m_kind == 0) begin m_pres = done_presence; m_short = done_short; end
        if (m_kind == 2) m_rdata = done_byte;
      end
      if (spu_done) m_cfg = m_cfg & ~4;
      if (cmd_valid && rdy != 0) begin
        case (cmd_op)
          0: m_init();
          1: begin
               m_ptr = 2;
               if ((cmd_data >> 4) == (~cmd_data & 8'h0F)) begin
                 m_cfg = cmd_data & 8'h0F; m_rflag = 0;
               end
             end
          2: if (cmd_data[1:0] != 3) m_ptr = cmd_data[1:0];
          3, 4, 5: begin
               m_reqv = 1; m_busy = 1; m_ptr = 0;
               m_kind = cmd_op - 3; m_rqd = cmd_data;
             end
          default: ;
        endcase
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  // per-cycle comparison, half a period after the edge
  always @(negedge clk) if (rst_n && !finished) begin
    cmp("rd_data", rd_data, m_read());
    cmp("rd_sel", rd_sel, m_ptr);
    cmp("feat", feat, m_cfg);
    cmp("req_valid", req_valid, m_reqv);
    cmp("cmd_ready", cmd_ready, (m_busy == 0 || cmd_op == 0) ? 1 : 0);
    if (m_reqv != 0) begin
      cmp("req_kind", req_kind, m_kind);
      cmp("req_data", req_data, m_rqd);
    end
  end

  task automatic tick(); @(posedge clk); #2; endtask

  task automatic cmd(int op, int d);
    cmd_valid = 1; cmd_op = op[2:0]; cmd_data = d[7:0];
    tick();
    cmd_valid = 0; cmd_op = 0; cmd_data = 0;
  endtask

  task automatic done(int pres, int shrt, int b);
    done_valid = 1; done_presence = pres[0]; done_short = shrt[0]; done_byte = b[7:0];
    tick();
    done_valid = 0; done_presence = 0; done_short = 0; done_byte = 0;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    chk("R1", "status after reset", rd_data, 8'h08);
    chk("R1", "pointer after reset", rd_sel, 0);

    cur_req = "R10";
    cmd(1, 8'h4A);                         // near miss: 4 != ~A (5)
    chk("R10", "cfg after bad write", feat, 0);
    cmd(2, 0);
    chk("R10", "flag kept after bad write", rd_data, 8'h08);
    cmd(1, 8'h5A);                         // valid: lo A
    chk("R2", "cfg after valid write", feat, 4'hA);
    chk("R2", "pointer after write", rd_sel, 2);
    cmd(2, 0);
    chk("R10", "flag cleared", rd_data, 8'h00);

    cur_req = "R2";
    cmd(1, 8'h33);
    chk("R2", "cfg after rejected 33", feat, 4'hA);
    chk("R2", "pointer after rejected", rd_sel, 2);
    cur_req = "R3";
    chk("R3", "config read upper nibble", rd_data, 8'h0A);

    cur_req = "R4";
    cmd(1, 8'h0F);                         // all features on
    chk("R4", "all features", feat, 4'hF);
    spu_done = 1; tick(); spu_done = 0;
    chk("R4", "spu self clear", feat, 4'hB);
    spu_done = 1; cmd(1, 8'hB4); spu_done = 0;
    chk("R4", "write wins over spu_done", feat, 4'h4);

    cur_req = "R5";
    cmd(2, 1); chk("R5", "ptr data", rd_sel, 1);
    cmd(2, 3); chk("R5", "ptr code 3 ignored", rd_sel, 1);
    cmd(6, 2); chk("R5", "op 6 ignored", rd_sel, 1);
    cmd(7, 0); chk("R5", "op 7 ignored", rd_sel, 1);
    cmd(2, 2); chk("R5", "ptr config", rd_sel, 2);

    cur_req = "R6";
    cmd(5, 8'h77);                         // read byte, engine holds off
    chk("R6", "req kind", req_kind, 2);
    chk("R6", "status busy", rd_data, 8'h01);
    cur_req = "R7";
    cmd(4, 8'h11);                         // must stall
    cmd(2, 1);                             // must stall
    chk("R7", "ptr untouched while busy", rd_sel, 0);
    chk("R7", "kind unchanged", req_kind, 2);
    req_ready = 1; tick(); req_ready = 0;
    chk("R6", "req dropped after handshake", req_valid, 0);
    cur_req = "R8";
    done(0, 0, 8'h9C);
    chk("R8", "busy cleared", rd_data, 8'h00);
    cmd(2, 1);
    chk("R8", "read data loaded", rd_data, 8'h9C);
    cmd(3, 0);
    req_ready = 1; tick(); req_ready = 0;
    done(1, 1, 8'h55);
    chk("R8", "presence and short", rd_data, 8'h06);
    cmd(4, 8'hC3);
    req_ready = 1; tick(); req_ready = 0;
    done(0, 0, 8'h12);
    chk("R8", "write byte keeps flags", rd_data, 8'h06);
    done(0, 0, 8'hEE);                     // idle: ignored
    cmd(2, 1);
    chk("R8", "idle done ignored", rd_data, 8'h9C);

    cur_req = "R9";
    cmd(5, 8'h01);
    chk("R9", "pending", req_valid, 1);
    cmd(0, 0);
    chk("R9", "request dropped", req_valid, 0);
    chk("R9", "reset status", rd_data, 8'h08);
    cur_req = "R1";
    chk("R1", "cfg after device reset", feat, 0);
    cmd(2, 1);
    chk("R1", "read data cleared", rd_data, 0);

    repeat (4) tick();
    finish_run();
  end
endmodule